// File: doc/BRIEF.md
# Shared-Window Descriptor Access Unit

This unit sits between a 16-bit front-end processor and a 36-bit host memory. Each front-end access arrives together with a 36-bit descriptor that the host has placed in a pointer table. The descriptor chooses how the access is served. In immediate mode the descriptor itself holds the data. In indirect mode the descriptor opens a 16-bit window onto one of four slice positions of a host word, and that window may be read-only. In pointer mode the descriptor walks through left-justified bytes of 16, 12, 8, 7 or 6 bits and counts down the words it is allowed to touch.

An access is accepted while `req_ready` is high. If memory is needed, a synchronous read is issued in the same cycle. In the following cycle the data is merged, and a write strobe is driven when the access writes. The response and its flags appear registered one cycle after that. For pointer mode the unit also returns the advanced descriptor, so that the table can be updated.

Bit numbering inside a 36-bit word counts from the most significant bit: position 0 is vector index 35. The descriptor fields sit at fixed places. The mode code is in positions 3-5 (`desc[32:30]`). The first field is in positions 0-2 (`desc[35:33]`). In indirect mode that first field is the read-only flag in `desc[35]` and the slice select in `desc[34:33]`. In pointer mode it is the byte index. The word count is in positions 6-17 (`desc[29:18]`). The word address is in the low 18 bits. Immediate data is in the low 16 bits.

Top module: `swin_xlate`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid`, `mem_rd_en`, `mem_wr_en` and `desc_wb_valid` are 0 while no request is presented.
- R2: A descriptor whose mode code is 0 or 7 is served as immediate. A read returns `desc[15:0]` and no memory read is issued.
- R3: A write with an immediate descriptor writes no memory and raises `rsp_viol` together with the response.
- R4: Mode code 1 is indirect. A read returns the 16-bit slice that the select field chooses: 0 gives positions 0-15, 1 gives 16-31, 2 gives 20-35 and 3 gives 2-17.
- R5: An indirect write with the read-only flag at 0 writes the host word back with only the 16 chosen positions replaced, and the other 20 bits kept.
- R6: An indirect write with the read-only flag at 1 writes no memory and raises `rsp_viol` for exactly one cycle.
- R7: Mode codes 2, 3, 4, 5 and 6 are pointer mode with byte sizes 16, 12, 8, 7 and 6. Byte i occupies positions i*size to (i+1)*size-1, and any low bits that are left over are unused. A read returns the byte zero-extended.
- R8: A pointer write replaces only the addressed byte, using the low `size` bits of `req_wdata`.
- R9: After a pointer transfer, `desc_wb` holds the descriptor with the byte index incremented. When the index reaches the number of bytes per word, the index returns to 0, the address increments and the word count decrements.
- R10: A pointer access with word count 0 makes no memory access, returns 0, raises `rsp_wc_ovf` and gives no `desc_wb_valid`.
- R11: A pointer descriptor whose byte index is not below the number of bytes per word is undefined. It returns 0, raises `rsp_mode_err` and makes no memory access.
- R12: After an accepted request `req_ready` is low for one cycle. `mem_wr_en` can only be high in that cycle. `rsp_valid` pulses for one cycle, two cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Front-end access request |
| req_ready | output | 1 | Unit can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Front-end write data |
| req_desc | input | 36 | Descriptor that steers this access |
| mem_rd_en | output | 1 | Synchronous host memory read strobe |
| mem_addr | output | ADDR_W | Host word address |
| mem_rdata | input | 36 | Host word, valid one cycle after `mem_rd_en` |
| mem_wr_en | output | 1 | Host memory write strobe |
| mem_wdata | output | 36 | Merged host word to write |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 16 | Value returned to the front end |
| rsp_viol | output | 1 | Write refused by a read-only or immediate window |
| rsp_wc_ovf | output | 1 | Pointer access with word count exhausted |
| rsp_mode_err | output | 1 | Undefined pointer descriptor |
| desc_wb_valid | output | 1 | `desc_wb` holds an advanced pointer descriptor |
| desc_wb | output | 36 | Advanced pointer descriptor |

## Verification
The assertions check on every cycle the handshake timing of R12. They also check that a refused write never reaches the memory strobe (R3, R6), that the violation, overflow and undefined flags are mutually exclusive, and that an overflow never produces a descriptor write-back. The actual data cannot be seen by a property, so only the bench scenarios show it. This covers the slice chosen by each select value, the overlapping slices after a merge, the byte boundaries for each of the five sizes including the unused tail bit at size 7, and the index wrap that moves the address and word count. These are compared against a bit-by-bit model of the host memory.

// File: rtl/swin_pkg.sv
package swin_pkg;
  localparam int WORD_W = 36;
  localparam int DATA_W = 16;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {K_IMM, K_IND, K_PTR} kind_e;
  typedef enum logic {ST_IDLE, ST_DATA} state_e;

  // right-shift that aligns the selected 16-bit slice to bit 0
  function automatic logic [5:0] slice_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd20;
      2'd1:    return 6'd4;
      2'd2:    return 6'd0;
      default: return 6'd18;
    endcase
  endfunction

  function automatic logic [4:0] byte_size(input logic [MODE_W-1:0] code);
    case (code)
      3'd2:    return 5'd16;
      3'd3:    return 5'd12;
      3'd4:    return 5'd8;
      3'd5:    return 5'd7;
      3'd6:    return 5'd6;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [2:0] bytes_per_word(input logic [MODE_W-1:0] code);
    case (code)
      3'd2:    return 3'd2;
      3'd3:    return 3'd3;
      3'd4:    return 3'd4;
      3'd5:    return 3'd5;
      3'd6:    return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  // right-shift that aligns byte idx (counted from the left) to bit 0
  function automatic logic [5:0] byte_shift(input logic [4:0] size, input logic [2:0] idx);
    int sh;
    sh = WORD_W - (int'(idx) + 1) * int'(size);
    if (sh < 0) sh = 0;
    return sh[5:0];
  endfunction

  function automatic logic [DATA_W-1:0] byte_mask(input logic [4:0] size);
    int m;
    m = (1 << size) - 1;
    return m[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/swin_decode.sv
module swin_decode
  import swin_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic [WORD_W-1:0]       desc,
  output kind_e                   kind,
  output logic                    ro,
  output logic [1:0]              sel,
  output logic [MODE_W-1:0]       mode,
  output logic [2:0]              idx,
  output logic [4:0]              size,
  output logic [2:0]              bpw,
  output logic                    idx_ok,
  output logic [WORD_W-6-ADDR_W-1:0] wc,
  output logic [ADDR_W-1:0]       addr,
  output logic [DATA_W-1:0]       imm
);
  localparam int WC_W = WORD_W - 6 - ADDR_W;

  always_comb begin
    mode = desc[WORD_W-4 -: MODE_W];
    idx  = desc[WORD_W-1 -: 3];
    ro   = desc[WORD_W-1];
    sel  = desc[WORD_W-2 -: 2];
    wc   = desc[ADDR_W +: WC_W];
    addr = desc[ADDR_W-1:0];
    imm  = desc[DATA_W-1:0];
    size = byte_size(mode);
    bpw  = bytes_per_word(mode);
    case (mode)
      3'd0, 3'd7: kind = K_IMM;
      3'd1:       kind = K_IND;
      default:    kind = K_PTR;
    endcase
    idx_ok = (idx < bpw);
  end
endmodule

// File: rtl/swin_merge.sv
module swin_merge
  import swin_pkg::*;
(
  input  kind_e              kind,
  input  logic [1:0]         sel,
  input  logic [4:0]         size,
  input  logic [2:0]         idx,
  input  logic [WORD_W-1:0]  word,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rd_val,
  output logic [WORD_W-1:0]  merged
);
  logic [5:0]        sh;
  logic [DATA_W-1:0] fmask;
  logic [WORD_W-1:0] wmask;
  logic [WORD_W-1:0] aligned;
  logic [WORD_W-1:0] ins;

  always_comb begin
    if (kind == K_IND) begin
      sh    = slice_shift(sel);
      fmask = '1;
    end else begin
      sh    = byte_shift(size, idx);
      fmask = byte_mask(size);
    end
    aligned = word >> sh;
    rd_val  = aligned[DATA_W-1:0] & fmask;
    wmask   = {{(WORD_W-DATA_W){1'b0}}, fmask} << sh;
    ins     = {{(WORD_W-DATA_W){1'b0}}, wdata & fmask} << sh;
    merged  = (word & ~wmask) | ins;
  end
endmodule

// File: rtl/swin_ptr_step.sv
module swin_ptr_step #(
  parameter int ADDR_W = 18,
  parameter int WC_W   = 12
) (
  input  logic [2:0]        idx,
  input  logic [2:0]        bpw,
  input  logic [WC_W-1:0]   wc,
  input  logic [ADDR_W-1:0] addr,
  output logic              wrap,
  output logic [2:0]        nidx,
  output logic [WC_W-1:0]   nwc,
  output logic [ADDR_W-1:0] naddr
);
  logic [2:0] inc;

  always_comb begin
    inc  = idx + 3'd1;
    wrap = (inc == bpw);
    if (wrap) begin
      nidx  = 3'd0;
      nwc   = wc - WC_W'(1);
      naddr = addr + ADDR_W'(1);
    end else begin
      nidx  = inc;
      nwc   = wc;
      naddr = addr;
    end
  end
endmodule

// File: rtl/swin_xlate.sv
module swin_xlate
  import swin_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [WORD_W-1:0]   req_desc,
  output logic                mem_rd_en,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic                mem_wr_en,
  output logic [WORD_W-1:0]   mem_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_viol,
  output logic                rsp_wc_ovf,
  output logic                rsp_mode_err,
  output logic                desc_wb_valid,
  output logic [WORD_W-1:0]   desc_wb
);
  localparam int WC_W = WORD_W - 6 - ADDR_W;

  state_e              state;
  logic [WORD_W-1:0]   l_desc;
  logic                l_write;
  logic [DATA_W-1:0]   l_wdata;
  logic [WORD_W-1:0]   cur_desc;
  logic                in_data;
  logic                accept;

  kind_e               d_kind;
  logic                d_ro;
  logic [1:0]          d_sel;
  logic [MODE_W-1:0]   d_mode;
  logic [2:0]          d_idx;
  logic [4:0]          d_size;
  logic [2:0]          d_bpw;
  logic                d_idx_ok;
  logic [WC_W-1:0]     d_wc;
  logic [ADDR_W-1:0]   d_addr;
  logic [DATA_W-1:0]   d_imm;

  logic [DATA_W-1:0]   m_rd;
  logic [WORD_W-1:0]   m_merged;
  logic                s_wrap;
  logic [2:0]          s_idx;
  logic [WC_W-1:0]     s_wc;
  logic [ADDR_W-1:0]   s_addr;

  // named events, also observed by the checker
  logic                need_mem;
  logic                ev_ro_block;
  logic                ev_ovf;
  logic                ev_bad;
  logic                ev_ptr_ok;
  logic                ev_wr;
  logic [DATA_W-1:0]   rd_next;

  assign in_data  = (state == ST_DATA);
  assign req_ready = (state == ST_IDLE);
  assign accept   = req_ready && req_valid;
  assign cur_desc = in_data ? l_desc : req_desc;

  swin_decode #(.ADDR_W(ADDR_W)) u_dec (
    .desc(cur_desc), .kind(d_kind), .ro(d_ro), .sel(d_sel), .mode(d_mode),
    .idx(d_idx), .size(d_size), .bpw(d_bpw), .idx_ok(d_idx_ok),
    .wc(d_wc), .addr(d_addr), .imm(d_imm)
  );

  swin_merge u_merge (
    .kind(d_kind), .sel(d_sel), .size(d_size), .idx(d_idx),
    .word(mem_rdata), .wdata(l_wdata), .rd_val(m_rd), .merged(m_merged)
  );

  swin_ptr_step #(.ADDR_W(ADDR_W), .WC_W(WC_W)) u_step (
    .idx(d_idx), .bpw(d_bpw), .wc(d_wc), .addr(d_addr),
    .wrap(s_wrap), .nidx(s_idx), .nwc(s_wc), .naddr(s_addr)
  );

  always_comb begin
    need_mem    = (d_kind == K_IND) ||
                  ((d_kind == K_PTR) && d_idx_ok && (d_wc != '0));
    ev_ro_block = in_data && l_write &&
                  ((d_kind == K_IMM) || ((d_kind == K_IND) && d_ro));
    ev_ovf      = in_data && (d_kind == K_PTR) && d_idx_ok && (d_wc == '0);
    ev_bad      = in_data && (d_kind == K_PTR) && !d_idx_ok;
    ev_ptr_ok   = in_data && (d_kind == K_PTR) && d_idx_ok && (d_wc != '0);
    ev_wr       = in_data && l_write &&
                  (((d_kind == K_IND) && !d_ro) || ev_ptr_ok);
    case (d_kind)
      K_IMM:   rd_next = d_imm;
      K_IND:   rd_next = m_rd;
      default: rd_next = ev_ptr_ok ? m_rd : '0;
    endcase
  end

  assign mem_rd_en = accept && need_mem;
  assign mem_addr  = d_addr;
  assign mem_wr_en = ev_wr;
  assign mem_wdata = m_merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      l_desc  <= '0;
      l_write <= 1'b0;
      l_wdata <= '0;
    end else if (accept) begin
      state   <= ST_DATA;
      l_desc  <= req_desc;
      l_write <= req_write;
      l_wdata <= req_wdata;
    end else begin
      state   <= ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      rsp_viol      <= 1'b0;
      rsp_wc_ovf    <= 1'b0;
      rsp_mode_err  <= 1'b0;
      desc_wb_valid <= 1'b0;
      desc_wb       <= '0;
    end else begin
      rsp_valid     <= in_data;
      rsp_viol      <= ev_ro_block;
      rsp_wc_ovf    <= ev_ovf;
      rsp_mode_err  <= ev_bad;
      desc_wb_valid <= ev_ptr_ok;
      if (in_data) rsp_rdata <= rd_next;
      if (ev_ptr_ok) desc_wb <= {s_idx, d_mode, s_wc, s_addr};
    end
  end
endmodule

// File: rtl/swin_xlate_chk.sv
module swin_xlate_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic mem_rd_en,
  input logic mem_wr_en,
  input logic rsp_valid,
  input logic rsp_viol,
  input logic rsp_wc_ovf,
  input logic rsp_mode_err,
  input logic desc_wb_valid,
  input logic ev_ro_block
);
  assert_busy_after_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_rsp_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ##1 rsp_valid);
  assert_rsp_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_wr_in_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> !req_ready);
  assert_wr_then_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> rsp_valid);
  assert_rd_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (req_valid && req_ready));
  assert_ro_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ro_block |-> !mem_wr_en);
  assert_ro_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ro_block |=> (rsp_viol && rsp_valid));
  assert_flag_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_viol |=> !rsp_viol);
  assert_ovf_no_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wc_ovf |-> !desc_wb_valid);
  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_viol, rsp_wc_ovf, rsp_mode_err, desc_wb_valid}));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wb_valid |-> rsp_valid);
endmodule

bind swin_xlate swin_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .rsp_valid(rsp_valid),
  .rsp_viol(rsp_viol), .rsp_wc_ovf(rsp_wc_ovf), .rsp_mode_err(rsp_mode_err),
  .desc_wb_valid(desc_wb_valid), .ev_ro_block(ev_ro_block)
);

// File: tb/swin_xlate_bench.sv
module swin_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [35:0] req_desc = '0;
  logic        mem_rd_en;
  logic [17:0] mem_addr;
  logic [35:0] mem_rdata = '0;
  logic        mem_wr_en;
  logic [35:0] mem_wdata;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        rsp_viol, rsp_wc_ovf, rsp_mode_err, desc_wb_valid;
  logic [35:0] desc_wb;

  int tests = 0;
  int fails = 0;
  logic [35:0] bmem [0:63];
  logic [35:0] ref_mem [0:63];
  logic [35:0] last_wb = '0;

  always #2 clk = ~clk;

  swin_xlate u_swin_xlate (.*);

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= bmem[mem_addr[5:0]];
    if (mem_wr_en) bmem[mem_addr[5:0]] <= mem_wdata;
  end

  task automatic check(input string rq, input string what, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h exp %h", rq, what, got, exp);
    end
  endtask

  function automatic logic [15:0] ref_get(input logic [35:0] w, input int start, input int len);
    logic [15:0] r = '0;
    for (int k = 0; k < len; k++) r[len-1-k] = w[35-start-k];
    return r;
  endfunction

  function automatic logic [35:0] ref_put(input logic [35:0] w, input int start, input int len, input logic [15:0] v);
    logic [35:0] r = w;
    for (int k = 0; k < len; k++) r[35-start-k] = v[len-1-k];
    return r;
  endfunction

  function automatic int ref_size(input logic [2:0] code);
    int t [7] = '{0, 0, 16, 12, 8, 7, 6};
    return t[code];
  endfunction

  function automatic logic [35:0] mk_imm(input logic [2:0] code, input logic [15:0] v);
    return {3'b101, code, 14'h2AB, v};
  endfunction
  function automatic logic [35:0] mk_ind(input logic ro, input logic [1:0] p, input logic [17:0] a);
    return {ro, p, 3'd1, 12'hF0F, a};
  endfunction
  function automatic logic [35:0] mk_ptr(input logic [2:0] i, input logic [2:0] s, input logic [11:0] wc, input logic [17:0] a);
    return {i, s, wc, a};
  endfunction

  task automatic access(input logic [35:0] d, input logic wr, input logic [15:0] wd, input string rq);
    logic [2:0]  code = d[32:30];
    int          a = int'(d[5:0]);
    logic [15:0] e_rd = '0;
    logic        e_viol = 0, e_ovf = 0, e_err = 0, e_wbv = 0, e_mrd = 0, e_mwr = 0;
    logic [35:0] e_wb = '0;
    logic [35:0] e_word = ref_mem[a];
    if (code == 3'd0 || code == 3'd7) begin
      e_rd = d[15:0];
      e_viol = wr;
    end else if (code == 3'd1) begin
      int st = (d[34:33] == 0) ? 0 : (d[34:33] == 1) ? 16 : (d[34:33] == 2) ? 20 : 2;
      e_mrd = 1;
      e_rd = ref_get(ref_mem[a], st, 16);
      if (wr && d[35]) e_viol = 1;
      else if (wr) begin e_mwr = 1; e_word = ref_put(ref_mem[a], st, 16, wd); end
    end else begin
      int sz = ref_size(code);
      int per = 36 / sz;
      int ix = int'(d[35:33]);
      int wc = int'(d[29:18]);
      if (ix >= per) e_err = 1;
      else if (wc == 0) e_ovf = 1;
      else begin
        e_mrd = 1;
        e_wbv = 1;
        e_rd = ref_get(ref_mem[a], ix * sz, sz);
        if (wr) begin e_mwr = 1; e_word = ref_put(ref_mem[a], ix * sz, sz, wd); end
        if (ix + 1 == per) e_wb = {3'd0, code, 12'(wc - 1), d[17:0] + 18'd1};
        else e_wb = {3'(ix + 1), code, d[29:0]};
      end
    end
    // N0: present request
    @(negedge clk);
    req_valid = 1; req_desc = d; req_write = wr; req_wdata = wd;
    #0;
    check(rq, "ready before accept R12", req_ready, 1);
    check(rq, "memory read strobe", mem_rd_en, e_mrd);
    // N1: data cycle
    @(negedge clk);
    req_valid = 0;
    check(rq, "ready in data cycle R12", req_ready, 0);
    check(rq, "write strobe R12", mem_wr_en, e_mwr);
    if (e_mwr) check(rq, "merged word", mem_wdata, e_word);
    // N2: response
    @(negedge clk);
    check(rq, "rsp_valid R12", rsp_valid, 1);
    check(rq, "rdata", rsp_rdata, e_rd);
    check(rq, "viol", rsp_viol, e_viol);
    check(rq, "wc_ovf", rsp_wc_ovf, e_ovf);
    check(rq, "mode_err", rsp_mode_err, e_err);
    check(rq, "wb_valid", desc_wb_valid, e_wbv);
    if (e_wbv) begin
      check(rq, "desc_wb R9", desc_wb, e_wb);
      last_wb = desc_wb;
    end
    ref_mem[a] = e_word;
    check(rq, "memory word", bmem[a], ref_mem[a]);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog: got hang exp completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      bmem[i] = 36'h9C3A5E172 ^ (36'(i) * 36'd2654435761);
      ref_mem[i] = bmem[i];
    end
    repeat (3) @(negedge clk);
    check("R1", "ready after reset", req_ready, 1);
    check("R1", "rsp_valid after reset", rsp_valid, 0);
    check("R1", "strobes after reset", {mem_rd_en, mem_wr_en, desc_wb_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "idle quiet", {rsp_valid, mem_rd_en, mem_wr_en}, 0);

    access(mk_imm(3'd0, 16'hBEEF), 0, 16'h0, "R2");
    access(mk_imm(3'd7, 16'h1234), 0, 16'h0, "R2");
    access(mk_imm(3'd0, 16'h5555), 1, 16'hFFFF, "R3");

    for (int p = 0; p < 4; p++) access(mk_ind(1'b0, 2'(p), 18'd5), 0, 16'h0, "R4");
    access(mk_ind(1'b0, 2'd2, 18'd6), 1, 16'hA5A5, "R5");
    access(mk_ind(1'b0, 2'd3, 18'd6), 1, 16'h0F0F, "R5");
    access(mk_ind(1'b0, 2'd1, 18'd6), 0, 16'h0, "R5");
    access(mk_ind(1'b1, 2'd1, 18'd7), 1, 16'h1111, "R6");
    access(mk_ind(1'b1, 2'd0, 18'd7), 0, 16'h0, "R6");

    access(mk_ptr(3'd0, 3'd4, 12'd2, 18'd10), 0, 16'h0, "R7");
    for (int k = 0; k < 4; k++) access(last_wb, 0, 16'h0, "R9");
    access(mk_ptr(3'd3, 3'd5, 12'd1, 18'd20), 0, 16'h0, "R7");
    access(last_wb, 0, 16'h0, "R9");
    access(last_wb, 0, 16'h0, "R10");
    access(mk_ptr(3'd5, 3'd6, 12'd3, 18'd22), 0, 16'h0, "R7");
    access(mk_ptr(3'd2, 3'd3, 12'd3, 18'd23), 0, 16'h0, "R7");
    access(mk_ptr(3'd1, 3'd2, 12'd3, 18'd24), 0, 16'h0, "R7");
    access(mk_ptr(3'd2, 3'd5, 12'd1, 18'd30), 1, 16'h7F5A, "R8");
    access(mk_ptr(3'd0, 3'd3, 12'd9, 18'd31), 1, 16'hFABC, "R8");
    access(mk_ptr(3'd4, 3'd5, 12'd1, 18'd30), 1, 16'h0000, "R8");
    access(mk_ptr(3'd2, 3'd2, 12'd4, 18'd25), 0, 16'h0, "R11");
    access(mk_ptr(3'd5, 3'd5, 12'd4, 18'd26), 1, 16'h1234, "R11");
    access(mk_ptr(3'd0, 3'd4, 12'd0, 18'd27), 1, 16'h00FF, "R10");

    @(negedge clk);
    check("R12", "rsp pulse ends", rsp_valid, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule